// File: doc/BRIEF.md
# Clock-Enable Prescaler Tree

This block turns a single fast root clock into seven clock-enable strobes. Each strobe stands in for one derived clock of a small microcontroller: the host bus, a system tick, two peripheral buses, a timer clock on each peripheral bus, and a converter clock. Every strobe is one root-clock cycle wide and synchronous to the root clock. A consumer runs its logic on the root clock and advances only in cycles where its strobe is high.

The host-bus stage divides the root clock. The two peripheral-bus stages and the tick stage count host-bus strobes. The converter stage counts strobes of the second peripheral bus. The divide selects and the per-consumer gate bits are static register inputs. A gate only silences its own output. Stages downstream of a gated output keep counting the ungated parent events, so their rates do not change.

A new divide select takes effect at the end of the current output period of its stage. Partial or extra periods therefore never appear.

Top module: `clk_strobe_tree`

## Requirements
- R1: The host strobe (`stb_o[0]`) fires once every N root cycles. `host_sel` codes 0 to 7 give N=1. Codes 8, 9, 10, 11, 12, 13, 14 and 15 give N = 2, 4, 8, 16, 64, 128, 256 and 512.
- R2: Each peripheral-bus strobe (`stb_o[2]` for bus A, `stb_o[4]` for bus B) fires once every P host strobes. Select codes 0 to 3 give P=1, and codes 4, 5, 6 and 7 give P = 2, 4, 8 and 16. The two buses are selected independently.
- R3: Each timer strobe (`stb_o[3]` for bus A, `stb_o[5]` for bus B) equals its bus strobe when P=1. For any other P it fires twice per bus period, once every P/2 host strobes, and always together with the bus strobe.
- R4: The converter strobe (`stb_o[6]`) fires once every 2*(c+1) bus-B strobes, where c is the 2-bit `conv_sel` value. This gives ratios 2, 4, 6 and 8.
- R5: The tick strobe (`stb_o[1]`) fires once every 8 host strobes.
- R6: While `gate_en[i]` is 0, `stb_o[i]` stays low. Gating an output does not change the rate of any other output.
- R7: Outputs are registered. A strobe is due in the cycle after the stage's period ends. At a ratio of 1 the strobe is high on every cycle of its parent.
- R8: Synchronous reset clears all counters and outputs. After reset is released, an output with total period T (in root cycles) first fires on the T-th rising edge, then again every T cycles.
- R9: A change of any divide select takes effect only after the current period of that stage completes. The strobe that ends this period keeps the old spacing, and the next period uses the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Root clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 4 | Host-bus divide select |
| pbus_sel_a | input | 3 | Peripheral bus A divide select |
| pbus_sel_b | input | 3 | Peripheral bus B divide select |
| conv_sel | input | 2 | Converter divide select |
| gate_en | input | 7 | Per-output enable, same bit order as `stb_o` |
| stb_o | output | 7 | Strobes: 0 host, 1 tick, 2 bus A, 3 timer A, 4 bus B, 5 timer B, 6 converter |

## Verification
Every output of a stage with total period T rises after the T-th, 2T-th, 3T-th rising edge that follows reset release. That count already includes the single output register, so each result is due exactly T edges after the previous one. The bench counts edges from reset release and samples `stb_o` 1 ns after each edge. It compares the edge number of the first strobe with T and the gap between successive strobes with T. It also compares the strobe count over a fixed window with the window length divided by T. For the select-change test, the new select is applied between edges in the middle of a host period. The bench then expects one more strobe at the old spacing before the new spacing begins.

// File: rtl/cstree_pkg.sv
package cstree_pkg;
  localparam int HOST_CW = 9;
  localparam int PBUS_CW = 4;
  localparam int CONV_CW = 3;
  localparam int N_PBUS  = 2;
  localparam int N_STB   = 7;

  localparam int S_HOST = 0;
  localparam int S_TICK = 1;
  localparam int S_PA   = 2;
  localparam int S_TA   = 3;
  localparam int S_PB   = 4;
  localparam int S_TB   = 5;
  localparam int S_CONV = 6;

  // Terminal count (ratio - 1) of the host stage; the ratio 32 is skipped.
  function automatic logic [HOST_CW-1:0] host_term(input logic [3:0] code);
    logic [3:0]       e;
    logic [HOST_CW:0] v;
    if (!code[3]) return '0;
    e = code[2] ? {1'b0, code[2:0]} + 4'd2 : {1'b0, code[2:0]} + 4'd1;
    v = (HOST_CW+1)'(1) << e;
    return HOST_CW'(v - (HOST_CW+1)'(1));
  endfunction

  // Terminal count of a peripheral-bus stage: ratios 1,2,4,8,16.
  function automatic logic [PBUS_CW-1:0] pbus_term(input logic [2:0] code);
    logic [PBUS_CW:0] v;
    if (!code[2]) return '0;
    v = (PBUS_CW+1)'(1) << ({1'b0, code[1:0]} + 3'd1);
    return PBUS_CW'(v - (PBUS_CW+1)'(1));
  endfunction

  // Terminal count of the converter stage: ratios 2,4,6,8.
  function automatic logic [CONV_CW-1:0] conv_term(input logic [1:0] code);
    return CONV_CW'({code, 1'b1});
  endfunction
endpackage

// File: rtl/div_stage.sv
// Counts parent events; fires on the event that closes a period.
// The ratio is reloaded only when a period closes.
module div_stage #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_in,
  input  logic [CW-1:0] term_next,
  output logic          strobe
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term_q;

  assign strobe = tick_in && (cnt_q == term_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      term_q <= term_next;
    end else if (strobe) begin
      cnt_q  <= '0;
      term_q <= term_next;
    end else if (tick_in) begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/bus_stage.sv
// Peripheral-bus divider with its timer rule. The timer fires at the
// period end and, for ratios above 1, also at the parent-count midpoint.
module bus_stage #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_in,
  input  logic [CW-1:0] term_next,
  output logic          bus_stb,
  output logic          tmr_stb
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term_q;
  logic          mid_hit;

  assign bus_stb = tick_in && (cnt_q == term_q);
  assign mid_hit = tick_in && (term_q != '0) && (cnt_q == (term_q >> 1));
  assign tmr_stb = bus_stb || mid_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      term_q <= term_next;
    end else if (bus_stb) begin
      cnt_q  <= '0;
      term_q <= term_next;
    end else if (tick_in) begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/clk_strobe_tree.sv
module clk_strobe_tree
  import cstree_pkg::*;
#(
  parameter int TICK_RATIO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       host_sel,
  input  logic [2:0]       pbus_sel_a,
  input  logic [2:0]       pbus_sel_b,
  input  logic [1:0]       conv_sel,
  input  logic [N_STB-1:0] gate_en,
  output logic [N_STB-1:0] stb_o
);
  localparam int TICK_CW = $clog2(TICK_RATIO);

  logic               host_raw;
  logic               tick_raw;
  logic               conv_raw;
  logic [N_PBUS-1:0]  pbus_raw;
  logic [N_PBUS-1:0]  tmr_raw;
  logic [PBUS_CW-1:0] pterm [N_PBUS];
  logic [N_STB-1:0]   raw_all;
  logic [N_STB-1:0]   stb_q;

  div_stage #(.CW(HOST_CW)) u_host (
    .clk(clk), .rst(rst), .tick_in(1'b1),
    .term_next(host_term(host_sel)), .strobe(host_raw)
  );

  div_stage #(.CW(TICK_CW)) u_tick (
    .clk(clk), .rst(rst), .tick_in(host_raw),
    .term_next(TICK_CW'(TICK_RATIO - 1)), .strobe(tick_raw)
  );

  assign pterm[0] = pbus_term(pbus_sel_a);
  assign pterm[1] = pbus_term(pbus_sel_b);

  for (genvar g = 0; g < N_PBUS; g++) begin : g_bus
    bus_stage #(.CW(PBUS_CW)) u_bus (
      .clk(clk), .rst(rst), .tick_in(host_raw),
      .term_next(pterm[g]), .bus_stb(pbus_raw[g]), .tmr_stb(tmr_raw[g])
    );
  end

  div_stage #(.CW(CONV_CW)) u_conv (
    .clk(clk), .rst(rst), .tick_in(pbus_raw[1]),
    .term_next(conv_term(conv_sel)), .strobe(conv_raw)
  );

  always_comb begin
    raw_all         = '0;
    raw_all[S_HOST] = host_raw;
    raw_all[S_TICK] = tick_raw;
    raw_all[S_PA]   = pbus_raw[0];
    raw_all[S_TA]   = tmr_raw[0];
    raw_all[S_PB]   = pbus_raw[1];
    raw_all[S_TB]   = tmr_raw[1];
    raw_all[S_CONV] = conv_raw;
  end

  for (genvar i = 0; i < N_STB; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) stb_q[i] <= 1'b0;
      else     stb_q[i] <= raw_all[i] && gate_en[i];
    end
  end

  assign stb_o = stb_q;
endmodule

// File: rtl/cstree_chk.sv
module cstree_chk (
  input logic       clk,
  input logic       rst,
  input logic [6:0] gate_en,
  input logic [6:0] stb_o,
  input logic       host_raw,
  input logic       tick_raw,
  input logic [1:0] pbus_raw,
  input logic [1:0] tmr_raw,
  input logic       conv_raw
);
  // R2: bus events only coincide with host events
  a_r2_bus_on_host: assert property (@(posedge clk) disable iff (rst)
    (|pbus_raw) |-> host_raw);

  // R5: tick events only coincide with host events
  a_r5_tick_on_host: assert property (@(posedge clk) disable iff (rst)
    tick_raw |-> host_raw);

  // R3: every bus event is also a timer event
  a_r3_timer_covers_bus: assert property (@(posedge clk) disable iff (rst)
    (pbus_raw & ~tmr_raw) == 2'b00);

  // R4: converter events only coincide with bus B events
  a_r4_conv_on_bus_b: assert property (@(posedge clk) disable iff (rst)
    conv_raw |-> pbus_raw[1]);

  // R6: an output gated off in one cycle is low in the next
  a_r6_gated_quiet: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stb_o & ~$past(gate_en)) == 7'b0));

  // R8: outputs are low in the first cycle after reset
  a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stb_o == 7'b0));
endmodule

bind clk_strobe_tree cstree_chk u_chk (
  .clk(clk), .rst(rst), .gate_en(gate_en), .stb_o(stb_o),
  .host_raw(host_raw), .tick_raw(tick_raw), .pbus_raw(pbus_raw),
  .tmr_raw(tmr_raw), .conv_raw(conv_raw)
);

// File: tb/sim_clk_strobe_tree.sv
`timescale 1ns/1ps
module sim_clk_strobe_tree;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] host_sel = '0;
  logic [2:0] pbus_sel_a = '0;
  logic [2:0] pbus_sel_b = '0;
  logic [1:0] conv_sel = '0;
  logic [6:0] gate_en = '1;
  logic [6:0] stb_o;

  int nerr = 0;
  int nchk = 0;
  int m_cnt [7];
  int m_first [7];
  int m_last [7];
  int m_gap [7];
  int exp_t [7];

  localparam int W = 3000;
  localparam int NV = 7;
  // {host_sel, pbus_sel_a, pbus_sel_b, conv_sel}
  localparam logic [11:0] VEC [NV] = '{
    {4'd0,  3'd0, 3'd0, 2'd0},
    {4'd8,  3'd4, 3'd5, 2'd1},
    {4'd9,  3'd7, 3'd6, 2'd2},
    {4'd12, 3'd3, 3'd7, 2'd3},
    {4'd11, 3'd5, 3'd4, 2'd0},
    {4'd15, 3'd0, 3'd0, 2'd0},
    {4'd7,  3'd2, 3'd1, 2'd3}
  };

  always #2.5 clk = ~clk;

  clk_strobe_tree u0 (
    .clk(clk), .rst(rst), .host_sel(host_sel), .pbus_sel_a(pbus_sel_a),
    .pbus_sel_b(pbus_sel_b), .conv_sel(conv_sel), .gate_en(gate_en),
    .stb_o(stb_o)
  );

  function automatic int h_ratio(int c);
    case (c)
      8: return 2;   9: return 4;   10: return 8;   11: return 16;
      12: return 64; 13: return 128; 14: return 256; 15: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int p_ratio(int c);
    case (c)
      4: return 2; 5: return 4; 6: return 8; 7: return 16;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clear_meas();
    for (int b = 0; b < 7; b++) begin
      m_cnt[b] = 0; m_first[b] = 0; m_last[b] = 0; m_gap[b] = 0;
    end
  endtask

  // Observe edges k0..k1 counted from reset release; sample 1 ns after each edge.
  task automatic observe(input int k0, input int k1);
    for (int k = k0; k <= k1; k++) begin
      @(posedge clk);
      #1;
      for (int b = 0; b < 7; b++) begin
        if (stb_o[b]) begin
          if (m_first[b] == 0) m_first[b] = k;
          else if (k - m_last[b] != exp_t[b]) m_gap[b]++;
          m_last[b] = k;
          m_cnt[b]++;
        end
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    // R8: outputs low while reset is held
    repeat (3) @(negedge clk);
    check(stb_o == 7'b0, "R8 outputs in reset", int'(stb_o), 0);

    // Vector walk: R1 R2 R3 R4 R5 R7 R8 rates and first-strobe timing
    for (int v = 0; v < NV; v++) begin
      int h, pa, pb, cv;
      host_sel   = VEC[v][11:8];
      pbus_sel_a = VEC[v][7:5];
      pbus_sel_b = VEC[v][4:2];
      conv_sel   = VEC[v][1:0];
      gate_en    = '1;
      h  = h_ratio(int'(host_sel));
      pa = p_ratio(int'(pbus_sel_a));
      pb = p_ratio(int'(pbus_sel_b));
      cv = 2 * (int'(conv_sel) + 1);
      exp_t[0] = h;
      exp_t[1] = 8 * h;
      exp_t[2] = h * pa;
      exp_t[3] = (pa == 1) ? h : h * pa / 2;
      exp_t[4] = h * pb;
      exp_t[5] = (pb == 1) ? h : h * pb / 2;
      exp_t[6] = h * pb * cv;
      do_reset();
      clear_meas();
      observe(1, W);
      for (int b = 0; b < 7; b++) begin
        string tag;
        case (b)
          0: tag = "R1 host";
          1: tag = "R5 tick";
          2: tag = "R2 bus A";
          3: tag = "R3 timer A";
          4: tag = "R2 bus B";
          5: tag = "R3 timer B";
          default: tag = "R4 converter";
        endcase
        check(m_cnt[b] == W / exp_t[b], $sformatf("%s count vec %0d", tag, v),
              m_cnt[b], W / exp_t[b]);
        check(m_first[b] == ((exp_t[b] <= W) ? exp_t[b] : 0),
              $sformatf("R8 R7 %s first strobe vec %0d", tag, v),
              m_first[b], (exp_t[b] <= W) ? exp_t[b] : 0);
        check(m_gap[b] == 0, $sformatf("R7 %s spacing vec %0d", tag, v), m_gap[b], 0);
      end
    end

    // R6: gating tick and bus A leaves timer A and the others at full rate
    host_sel = 4'd8; pbus_sel_a = 3'd4; pbus_sel_b = 3'd0; conv_sel = 2'd0;
    gate_en = 7'b1111001;
    exp_t = '{2, 16, 4, 2, 2, 2, 4};
    do_reset();
    clear_meas();
    observe(1, 400);
    check(m_cnt[1] == 0, "R6 gated tick", m_cnt[1], 0);
    check(m_cnt[2] == 0, "R6 gated bus A", m_cnt[2], 0);
    check(m_cnt[3] == 200, "R6 timer A with bus A gated", m_cnt[3], 200);
    check(m_cnt[6] == 100, "R6 converter rate", m_cnt[6], 100);

    // R9: select change in mid-period keeps the running period
    host_sel = 4'd11; pbus_sel_a = 3'd0; pbus_sel_b = 3'd0; conv_sel = 2'd0;
    gate_en = '1;
    exp_t = '{16, 128, 16, 16, 16, 16, 32};
    do_reset();
    clear_meas();
    observe(1, 20);
    check(m_first[0] == 16, "R9 old period first strobe", m_first[0], 16);
    host_sel = 4'd8;
    clear_meas();
    exp_t[0] = 2;
    observe(21, 36);
    check(m_first[0] == 32, "R9 strobe closing old period", m_first[0], 32);
    check(m_cnt[0] == 3, "R9 strobes at new spacing", m_cnt[0], 3);
    check(m_gap[0] == 0, "R9 new spacing", m_gap[0], 0);

    // R1: code 7 still means divide-by-1 after a change
    host_sel = 4'd7;
    do_reset();
    clear_meas();
    exp_t[0] = 1;
    observe(1, 10);
    check(m_cnt[0] == 10, "R1 code 7 every cycle", m_cnt[0], 10);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule